// File: doc/BRIEF.md
# Request-Paced Memory-to-Peripheral Word Mover

This block is one DMA channel. It reads 32-bit words from memory and hands each one to a peripheral, for example the transmit FIFO of an audio serializer. The memory address advances by one word after every read. The peripheral address never changes. Software programs a start address, a destination address, a zero-based word count and a zero-based slice length. It then writes the control register with the enable bit and the hardware-trigger bit both set. From then on the peripheral paces the channel through its request line. Each request that the channel sees while it is idle moves one slice of words. When the last word has been delivered, the channel raises a completion flag, drops its active flag and clears its own enable bit.

The channel has two word streams. The memory read port uses valid/ready. The channel holds `mem_valid` and `mem_addr` steady until `mem_ready` is high at a clock edge, and the word on `mem_rdata` is taken at that same edge. The peripheral write port also uses valid/ready. The channel holds `per_valid`, `per_addr` and `per_data` steady until `per_ready` is high at a clock edge. Either side may stall for any number of cycles. The only time a valid signal drops without a handshake is when software writes the control register. Register reads are combinational on `reg_addr`. Register writes take effect at the clock edge where `reg_wen` is high.

Register map (word index on `reg_addr`):
- 0: source start address.
- 1: destination address.
- 2: zero-based word count.
- 3: zero-based slice length.
- 4: control. Bit 0 is enable. Bit 1 selects hardware-request pacing.
- 5: status.
  - Bit 0 is the done flag.
  - Bit 1 is the active flag.
  - Bit 8 masks the done interrupt.
  - Bit 9 masks the transfer interrupt.
  - Bit 10 masks the overflow interrupt.
- 6: current source address (read only).
- 7: words still to deliver (read only).

Top module: `mpdma_chan`

## Requirements
- R1: After reset, `mem_valid`, `per_valid` and `irq` are low. Status reads 0x700: both flags clear and all three masks set. Control reads 0, and the remaining-word register reads 0.
- R2: A write to control (index 4) with bit 0 set starts the channel. It loads the current source address from the source register and the remaining count with the count register plus one. It also sets the active flag (status bit 1).
- R3: No word moves while `dreq` is low. No word moves while control bit 1 is clear, even if `dreq` is high. In both cases the remaining count stays unchanged.
- R4: The k-th memory read, counting from zero, uses address source + 4k. Every peripheral write uses the destination register value as `per_addr`.
- R5: The peripheral receives the memory words in the order they were read, each unchanged.
- R6: Each request the channel sees while idle moves min(slice + 1, remaining) words. The slice completes even if `dreq` drops partway through. The next slice waits for a new request.
- R7: Once count + 1 words have been written, the channel stops issuing reads and writes. The done flag (bit 0) sets, the active flag clears and control bit 0 reads back 0.
- R8: `irq` is high exactly when the done flag is set and the done mask (status bit 8) is clear.
- R9: A status write loads bits 8 to 10 as masks. A 0 in bit 0 or bit 1 clears that flag. A 1 in either bit leaves the flag unchanged.
- R10: A write to control with bit 0 clear stops the channel. Both valid outputs are low from the next cycle onward, the active flag clears, and no further word moves.
- R11: While a valid output waits for its ready, it stays high and its address and data stay stable.
- R12: The current source address advances by 4 at each memory handshake. The remaining count falls by one at each peripheral handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 1 | Peripheral transfer request |
| mem_valid | output | 1 | Memory read request valid |
| mem_ready | input | 1 | Memory accepts request; data valid this cycle |
| mem_addr | output | AW | Memory read byte address |
| mem_rdata | input | DW | Memory read data |
| per_valid | output | 1 | Peripheral write valid |
| per_ready | input | 1 | Peripheral accepts word |
| per_addr | output | AW | Fixed peripheral address |
| per_data | output | DW | Word for the peripheral |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps word counts around one and two slice lengths against several slice lengths, with and without stalls on both streams. Each sweep point checks every address and every data word. An off-by-one in the zero-based count or slice length would show up here as a missing or extra word or a wrong completion. A single-cycle request is used to show that a whole slice still completes, that the channel then waits for the next request, and that the last slice is cut to the words that remain. A channel that checked the request again mid-slice, or ran past the total, would fail these checks. Further checks cover:
- stopping the channel mid-stream, which would expose a valid output held after the stop;
- disabling hardware pacing, which would expose movement without pacing;
- writing the status register, which would expose flags cleared when software writes ones, or an interrupt that ignores its mask.

// File: rtl/mpdma_pkg.sv
package mpdma_pkg;
  localparam int REG_IW = 3;

  localparam logic [REG_IW-1:0] RA_SRC   = 3'd0;
  localparam logic [REG_IW-1:0] RA_DST   = 3'd1;
  localparam logic [REG_IW-1:0] RA_CNT   = 3'd2;
  localparam logic [REG_IW-1:0] RA_SLICE = 3'd3;
  localparam logic [REG_IW-1:0] RA_CTRL  = 3'd4;
  localparam logic [REG_IW-1:0] RA_STAT  = 3'd5;
  localparam logic [REG_IW-1:0] RA_CSRC  = 3'd6;
  localparam logic [REG_IW-1:0] RA_CCNT  = 3'd7;

  // control bit positions
  localparam int CB_EN = 0;
  localparam int CB_HW = 1;

  // status bit positions
  localparam int SB_DONE  = 0;
  localparam int SB_ACT   = 1;
  localparam int SB_MDONE = 8;
  localparam int SB_MOVF  = 10;
  localparam int N_MASK   = SB_MOVF - SB_MDONE + 1;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RD   = 2'd1,
    ENG_WR   = 2'd2
  } eng_st_e;
endpackage

// File: rtl/mpdma_regs.sv
module mpdma_regs
  import mpdma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CNT_W   = 16,
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wen,
  input  logic [REG_IW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic               done_evt,
  output logic [AW-1:0]      src_cfg,
  output logic [AW-1:0]      dst_cfg,
  output logic [CNT_W-1:0]   cnt_cfg,
  output logic [SLICE_W-1:0] slice_cfg,
  output logic               run,
  output logic               hw_mode,
  output logic               start_evt,
  output logic               stop_evt
);
  logic ctrl_wr;

  assign ctrl_wr   = reg_wen && (reg_addr == RA_CTRL);
  assign start_evt = ctrl_wr && reg_wdata[CB_EN];
  assign stop_evt  = ctrl_wr && !reg_wdata[CB_EN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_cfg   <= '0;
      dst_cfg   <= '0;
      cnt_cfg   <= '0;
      slice_cfg <= '0;
    end else if (reg_wen) begin
      unique case (reg_addr)
        RA_SRC:   src_cfg   <= reg_wdata[AW-1:0];
        RA_DST:   dst_cfg   <= reg_wdata[AW-1:0];
        RA_CNT:   cnt_cfg   <= reg_wdata[CNT_W-1:0];
        RA_SLICE: slice_cfg <= reg_wdata[SLICE_W-1:0];
        default:  ;
      endcase
    end
  end

  // a software write to control wins over self-clear at terminal count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      hw_mode <= 1'b0;
    end else if (ctrl_wr) begin
      run     <= reg_wdata[CB_EN];
      hw_mode <= reg_wdata[CB_HW];
    end else if (done_evt) begin
      run     <= 1'b0;
    end
  end
endmodule

// File: rtl/mpdma_engine.sv
module mpdma_engine
  import mpdma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int CNT_W   = 16,
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               hw_mode,
  input  logic               start_evt,
  input  logic [AW-1:0]      src_cfg,
  input  logic [CNT_W-1:0]   cnt_cfg,
  input  logic [SLICE_W-1:0] slice_cfg,
  input  logic               dreq,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [AW-1:0]      mem_addr,
  input  logic [DW-1:0]      mem_rdata,
  output logic               per_valid,
  input  logic               per_ready,
  output logic [DW-1:0]      per_data,
  output logic [AW-1:0]      cur_src,
  output logic [CNT_W:0]     rem_cnt,
  output logic               done_evt
);
  localparam int REM_W = CNT_W + 1;
  localparam int STEP  = DW / 8;

  eng_st_e          st_q;
  logic [AW-1:0]    src_q;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] left_q;
  logic [DW-1:0]    data_q;
  logic [REM_W:0]   want_w;
  logic [REM_W-1:0] first_len;
  logic             go;
  logic             last_word;
  logic             slice_last;

  // words requested by one slice, clipped to what is left
  assign want_w     = (REM_W+1)'(slice_cfg) + (REM_W+1)'(1);
  assign first_len  = (want_w > {1'b0, rem_q}) ? rem_q : want_w[REM_W-1:0];
  assign go         = hw_mode && dreq && (rem_q != '0);
  assign last_word  = (rem_q == REM_W'(1));
  assign slice_last = (left_q == REM_W'(1));

  assign mem_valid = run && (st_q == ENG_RD);
  assign per_valid = run && (st_q == ENG_WR);
  assign mem_addr  = src_q;
  assign per_data  = data_q;
  assign cur_src   = src_q;
  assign rem_cnt   = rem_q;
  assign done_evt  = per_valid && per_ready && last_word && !start_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      src_q  <= '0;
      rem_q  <= '0;
      left_q <= '0;
      data_q <= '0;
    end else if (start_evt) begin
      st_q  <= ENG_IDLE;
      src_q <= src_cfg;
      rem_q <= {1'b0, cnt_cfg} + REM_W'(1);
    end else if (!run) begin
      st_q <= ENG_IDLE;
    end else begin
      unique case (st_q)
        ENG_IDLE: begin
          if (go) begin
            left_q <= first_len;
            st_q   <= ENG_RD;
          end
        end
        ENG_RD: begin
          if (mem_ready) begin
            data_q <= mem_rdata;
            src_q  <= src_q + AW'(STEP);
            st_q   <= ENG_WR;
          end
        end
        ENG_WR: begin
          if (per_ready) begin
            rem_q  <= rem_q - REM_W'(1);
            left_q <= left_q - REM_W'(1);
            st_q   <= (last_word || slice_last) ? ENG_IDLE : ENG_RD;
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mpdma_status.sv
module mpdma_status
  import mpdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [1:0]        wr_flags,
  input  logic [N_MASK-1:0] wr_masks,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              done_evt,
  output logic              done_flag,
  output logic              act_flag,
  output logic [N_MASK-1:0] masks,
  output logic              irq
);
  // one storage bit per interrupt mask, all masked out of reset
  for (genvar m = 0; m < N_MASK; m++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)       masks[m] <= 1'b1;
      else if (stat_wr) masks[m] <= wr_masks[m];
    end
  end

  // hardware set has priority over a software clear
  always_ff @(posedge clk) begin
    if (!rst_n)                          done_flag <= 1'b0;
    else if (done_evt)                   done_flag <= 1'b1;
    else if (stat_wr && !wr_flags[SB_DONE]) done_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          act_flag <= 1'b0;
    else if (start_evt)                  act_flag <= 1'b1;
    else if (stop_evt || done_evt)       act_flag <= 1'b0;
    else if (stat_wr && !wr_flags[SB_ACT]) act_flag <= 1'b0;
  end

  assign irq = done_flag && !masks[0];
endmodule

// File: rtl/mpdma_chan.sv
module mpdma_chan
  import mpdma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int CNT_W   = 16,
  parameter int SLICE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_IW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dreq,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              per_valid,
  input  logic              per_ready,
  output logic [AW-1:0]     per_addr,
  output logic [DW-1:0]     per_data,
  output logic              irq
);
  logic [AW-1:0]      src_cfg;
  logic [AW-1:0]      dst_cfg;
  logic [CNT_W-1:0]   cnt_cfg;
  logic [SLICE_W-1:0] slice_cfg;
  logic               run;
  logic               hw_mode;
  logic               start_evt;
  logic               stop_evt;
  logic               done_evt;
  logic               done_flag;
  logic               act_flag;
  logic [N_MASK-1:0]  masks;
  logic [AW-1:0]      cur_src;
  logic [CNT_W:0]     rem_cnt;

  mpdma_regs #(.AW(AW), .CNT_W(CNT_W), .SLICE_W(SLICE_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .done_evt  (done_evt),
    .src_cfg   (src_cfg),
    .dst_cfg   (dst_cfg),
    .cnt_cfg   (cnt_cfg),
    .slice_cfg (slice_cfg),
    .run       (run),
    .hw_mode   (hw_mode),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  mpdma_engine #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .SLICE_W(SLICE_W)) eng_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .hw_mode   (hw_mode),
    .start_evt (start_evt),
    .src_cfg   (src_cfg),
    .cnt_cfg   (cnt_cfg),
    .slice_cfg (slice_cfg),
    .dreq      (dreq),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .per_valid (per_valid),
    .per_ready (per_ready),
    .per_data  (per_data),
    .cur_src   (cur_src),
    .rem_cnt   (rem_cnt),
    .done_evt  (done_evt)
  );

  mpdma_status stat_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_wr   (reg_wen && (reg_addr == RA_STAT)),
    .wr_flags  (reg_wdata[SB_ACT:SB_DONE]),
    .wr_masks  (reg_wdata[SB_MOVF:SB_MDONE]),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .done_evt  (done_evt),
    .done_flag (done_flag),
    .act_flag  (act_flag),
    .masks     (masks),
    .irq       (irq)
  );

  assign per_addr = dst_cfg;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_SRC:   reg_rdata[AW-1:0]      = src_cfg;
      RA_DST:   reg_rdata[AW-1:0]      = dst_cfg;
      RA_CNT:   reg_rdata[CNT_W-1:0]   = cnt_cfg;
      RA_SLICE: reg_rdata[SLICE_W-1:0] = slice_cfg;
      RA_CTRL: begin
        reg_rdata[CB_EN] = run;
        reg_rdata[CB_HW] = hw_mode;
      end
      RA_STAT: begin
        reg_rdata[SB_DONE]          = done_flag;
        reg_rdata[SB_ACT]           = act_flag;
        reg_rdata[SB_MOVF:SB_MDONE] = masks;
      end
      RA_CSRC:  reg_rdata[AW-1:0]  = cur_src;
      RA_CCNT:  reg_rdata[CNT_W:0] = rem_cnt;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mpdma_chan_chk.sv
module mpdma_chan_chk
  import mpdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wen,
  input logic [REG_IW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [AW-1:0]     mem_addr,
  input logic              per_valid,
  input logic              per_ready,
  input logic [DW-1:0]     per_data,
  input logic              done_flag,
  input logic [AW-1:0]     cur_src,
  input logic [CNT_W:0]    rem_cnt
);
  localparam int STEP = DW / 8;

  logic ctrl_wr;
  assign ctrl_wr = reg_wen && (reg_addr == RA_CTRL);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !ctrl_wr) |=> (mem_valid && $stable(mem_addr)));

  // R11
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_valid && !per_ready && !ctrl_wr) |=> (per_valid && $stable(per_data)));

  // R12
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !ctrl_wr) |=> (cur_src == $past(cur_src) + AW'(STEP)));

  // R12
  rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_valid && per_ready && !ctrl_wr) |=> (rem_cnt == $past(rem_cnt) - (CNT_W+1)'(1)));

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !reg_wdata[CB_EN]) |=> (!mem_valid && !per_valid));

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(per_valid && per_ready));
endmodule

bind mpdma_chan mpdma_chan_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/mpdma_chan_tb_top.sv
`timescale 1ns/1ps
module mpdma_chan_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [31:0] SCRAMBLE = 32'hC3A5_5A3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dreq = 1'b0;
  logic        mem_valid, per_valid, irq;
  logic        mem_ready = 1'b0;
  logic        per_ready = 1'b0;
  logic [AW-1:0] mem_addr, per_addr;
  logic [DW-1:0] mem_rdata, per_data;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int mem_stall = 0;
  int per_stall = 0;
  int wr_seen = 0;
  int rd_seen = 0;
  bit hold_on = 1'b1;
  logic [31:0] exp_src = '0;
  logic [31:0] exp_dst = '0;
  logic        prev_mwait = 1'b0;
  logic        prev_pwait = 1'b0;
  logic [31:0] prev_maddr = '0;
  logic [31:0] prev_pdata = '0;

  always #2 clk = ~clk;

  assign mem_rdata = mem_addr ^ SCRAMBLE;

  mpdma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .per_valid(per_valid), .per_ready(per_ready),
    .per_addr(per_addr), .per_data(per_data), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // stream monitor and ready drivers, all away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
    if (hold_on && prev_mwait)
      check(mem_valid && (mem_addr == prev_maddr), "R11 mem hold", mem_addr, prev_maddr);
    if (hold_on && prev_pwait)
      check(per_valid && (per_data == prev_pdata), "R11 per hold", per_data, prev_pdata);
    mem_ready = (mem_stall == 0) || ((cyc % mem_stall) != 0);
    per_ready = (per_stall == 0) || (((cyc + 1) % per_stall) != 0);
    if (mem_valid && mem_ready) begin
      check(mem_addr == exp_src + 32'(4 * rd_seen), "R4 read addr", mem_addr, exp_src + 32'(4 * rd_seen));
      rd_seen++;
    end
    if (per_valid && per_ready) begin
      check(per_addr == exp_dst, "R4 dest addr", per_addr, exp_dst);
      check(per_data == ((exp_src + 32'(4 * wr_seen)) ^ SCRAMBLE), "R5 data",
            per_data, (exp_src + 32'(4 * wr_seen)) ^ SCRAMBLE);
      wr_seen++;
    end
    prev_mwait = mem_valid && !mem_ready;
    prev_pwait = per_valid && !per_ready;
    prev_maddr = mem_addr;
    prev_pdata = per_data;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup(input int cnt, input int slc, input logic [31:0] src, input logic [31:0] dst);
    wr(3'd5, 32'h0000_0600);
    wr(3'd0, src);
    wr(3'd1, dst);
    wr(3'd2, 32'(cnt));
    wr(3'd3, 32'(slc));
    exp_src = src; exp_dst = dst; wr_seen = 0; rd_seen = 0;
  endtask

  task automatic run_once(input int cnt, input int slc, input int ms, input int ps);
    logic [31:0] v;
    logic [31:0] src;
    int t;
    mem_stall = ms; per_stall = ps; dreq = 1'b0;
    src = 32'h1000_0000 + 32'(cnt * 1024) + 32'(slc * 64);
    setup(cnt, slc, src, 32'hF000_0040 ^ 32'(slc));
    wr(3'd4, 32'h3);
    rd(3'd6, v); check(v == src, "R2 cur src", v, src);
    rd(3'd7, v); check(v == 32'(cnt + 1), "R2 cur cnt", v, cnt + 1);
    rd(3'd5, v); check(v[1] == 1'b1, "R2 active", v[1], 1);
    dreq = 1'b1;
    t = 0;
    while (!irq && t < 4000) begin @(negedge clk); t++; end
    check(irq == 1'b1, "R8 irq at done", irq, 1);
    check(wr_seen == cnt + 1, "R7 words written", wr_seen, cnt + 1);
    check(rd_seen == cnt + 1, "R4 words read", rd_seen, cnt + 1);
    repeat (10) @(negedge clk);
    check(wr_seen == cnt + 1 && !mem_valid && !per_valid, "R7 quiet after done", wr_seen, cnt + 1);
    rd(3'd4, v); check(v[0] == 1'b0, "R7 enable self-clear", v[0], 0);
    rd(3'd5, v); check(v[1:0] == 2'b01, "R7 flags", v[1:0], 1);
    rd(3'd7, v); check(v == 32'd0, "R12 remaining zero", v, 0);
    rd(3'd6, v); check(v == src + 32'(4 * (cnt + 1)), "R12 src advanced", v, src + 32'(4 * (cnt + 1)));
    dreq = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    int counts[10] = '{0, 1, 2, 5, 7, 8, 9, 15, 16, 17};
    int slices[4]  = '{0, 1, 2, 7};
    int n;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!mem_valid && !per_valid && !irq, "R1 outputs idle", {mem_valid, per_valid, irq}, 0);
    rd(3'd5, v); check(v == 32'h700, "R1 status", v, 32'h700);
    rd(3'd4, v); check(v == 32'h0, "R1 control", v, 0);
    rd(3'd7, v); check(v == 32'h0, "R1 remaining", v, 0);

    // sweep of count, slice and stall pattern
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 4; j++)
          run_once(counts[i], slices[j], s ? 3 : 0, s ? 2 : 0);

    // R8 and R9 on the done flag left by the last run
    wr(3'd5, 32'h701);
    @(negedge clk);
    check(irq == 1'b0, "R8 masked irq", irq, 0);
    rd(3'd5, v); check(v[0] == 1'b1, "R9 write one keeps flag", v[0], 1);
    wr(3'd5, 32'h601);
    @(negedge clk);
    check(irq == 1'b1, "R8 unmasked irq", irq, 1);
    wr(3'd5, 32'h600);
    @(negedge clk);
    check(irq == 1'b0, "R9 cleared irq", irq, 0);
    rd(3'd5, v); check(v == 32'h600, "R9 write zero clears", v, 32'h600);

    // R3 and R6: single-cycle requests, slice of four over 21 words
    mem_stall = 0; per_stall = 0; dreq = 1'b0;
    setup(20, 3, 32'h2000_0100, 32'hF000_0080);
    wr(3'd4, 32'h3);
    repeat (20) @(negedge clk);
    check(wr_seen == 0, "R3 no request no move", wr_seen, 0);
    for (int p = 1; p <= 6; p++) begin
      @(negedge clk); dreq = 1'b1;
      @(negedge clk); dreq = 1'b0;
      repeat (40) @(negedge clk);
      check(wr_seen == ((4 * p > 21) ? 21 : 4 * p), "R6 words per request", wr_seen,
            (4 * p > 21) ? 21 : 4 * p);
    end
    rd(3'd5, v); check(v[0] == 1'b1, "R7 done after slices", v[0], 1);

    // R3: hardware pacing disabled
    setup(5, 7, 32'h3000_0000, 32'hF000_00C0);
    wr(3'd4, 32'h1);
    dreq = 1'b1;
    repeat (30) @(negedge clk);
    check(wr_seen == 0 && rd_seen == 0, "R3 no pacing no move", wr_seen + rd_seen, 0);
    rd(3'd7, v); check(v == 32'd6, "R3 count untouched", v, 6);
    dreq = 1'b0;
    wr(3'd4, 32'h0);

    // R10: stop mid-stream
    setup(200, 7, 32'h4000_0000, 32'hF000_0100);
    dreq = 1'b1;
    wr(3'd4, 32'h3);
    repeat (25) @(negedge clk);
    hold_on = 1'b0;
    wr(3'd4, 32'h0);
    check(!mem_valid && !per_valid, "R10 valids drop", {mem_valid, per_valid}, 0);
    n = wr_seen;
    repeat (30) @(negedge clk);
    check(wr_seen == n && n > 0, "R10 no move after stop", wr_seen, n);
    rd(3'd5, v); check(v[1:0] == 2'b00, "R10 flags after stop", v[1:0], 0);
    rd(3'd7, v); check(v == 32'(201 - n), "R12 remaining after stop", v, 201 - n);
    dreq = 1'b0;
    hold_on = 1'b1;

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule